// File: doc/BRIEF.md
# Prescaled PWM Channel with Programmable Edges

This block produces one pulse-width modulated output. A two-stage prescaler forms a time quantum from the input clock: a linear divider counts `cfg_div_lin + 1` cycles, and a power-of-two stage repeats that `2^cfg_div_shift` times. A period counter steps once per quantum from 0 up to `cfg_top` and then restarts. The output is active while the count lies inside a window set by two compare points, a start point and an end point. Equal points give a full-period active output. A start point above the end point gives a window that wraps across the period boundary.

Software-side logic loads all fields at once through a single write strobe. The four control bits (pin enable, count enable, invert, sync disable) act from the next cycle. The five timing fields go into a pending copy. They are moved into the active copy at the end of the running period. They move on the next cycle instead when sync is disabled, and continuously while counting is disabled, so values written during a stop apply as soon as counting resumes.

Top module: `pwm_edge_channel`

## Requirements
- R1: After a synchronous reset, every field is zero, both enables and the invert bit are clear, sync is active, and `pwm_out` is 0.
- R2: One quantum lasts `(cfg_div_lin + 1) * 2^cfg_div_shift` clock cycles (shift 4 bits, 0 to 15; linear divider 8 bits), and one period lasts `cfg_top + 1` quanta.
- R3: With start point below end point, the output is active while the count c satisfies start <= c < end. A start of 0 gives `end` active quanta per period.
- R4: When start equals end, the output is active for the whole period.
- R5: When start is above end, the output is active while c >= start or c < end.
- R6: With `cfg_pin_en` = 0, `pwm_out` sits at the inactive level (equal to the invert bit) one cycle after the control takes effect, whatever the counter holds.
- R7: With `cfg_clk_en` = 0, the prescaler and period counter are held at zero and the output is inactive. Timing written meanwhile applies from count 0 once counting is re-enabled.
- R8: Changing `cfg_invert` flips `pwm_out` on the cycle after the control register updates, with no wait for a period boundary.
- R9: With `cfg_sync_off` = 0, new timing fields take effect only at the end of the running period.
- R10: With `cfg_sync_off` = 1, new timing fields take effect on the cycle after the write, and the counter restarts if it is already past a shortened top.
- R11: `pwm_out` is a register. Its value in each cycle is the gated window function of the counter, active timing and controls of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Loads every configuration field below |
| cfg_div_lin | input | 8 | Linear divider, quantum factor is value + 1 |
| cfg_div_shift | input | 4 | Power-of-two factor of the quantum |
| cfg_top | input | 8 | Last count of a period |
| cfg_rise | input | 8 | Count where the active window starts |
| cfg_fall | input | 8 | Count where the active window ends |
| cfg_pin_en | input | 1 | 1 lets the window reach the pin |
| cfg_clk_en | input | 1 | 1 runs prescaler and counter |
| cfg_invert | input | 1 | 1 inverts the final output |
| cfg_sync_off | input | 1 | 1 applies timing at once instead of at period end |
| pwm_out | output | 1 | PWM output |

## Verification
The hardest case to reach is a timing write that lands partway through a period while sync is active. The old settings must then run on to the exact end of that period and hand over with no short or long pulse. This is hardest when the period is also shortened below the current count. The stimulus writes random timing, controls and sync mode at random gaps, with short dividers so that many boundaries pass. A cycle-level reference model in the bench follows every write. Directed runs then measure the active cycles over one whole period against the closed-form duty for plain, wrapped and full windows.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  localparam int unsigned LIN_W_DEF   = 8;
  localparam int unsigned SHIFT_W_DEF = 4;
  localparam int unsigned CNT_W_DEF   = 8;

  typedef struct packed {
    logic pin_en;
    logic clk_en;
    logic invert;
    logic sync_off;
  } pwm_ctrl_t;

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_chan_pkg::*;
#(
  parameter int unsigned LIN_W   = LIN_W_DEF,
  parameter int unsigned SHIFT_W = SHIFT_W_DEF,
  parameter int unsigned CNT_W   = CNT_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [LIN_W-1:0]   wr_lin,
  input  logic [SHIFT_W-1:0] wr_shift,
  input  logic [CNT_W-1:0]   wr_top,
  input  logic [CNT_W-1:0]   wr_rise,
  input  logic [CNT_W-1:0]   wr_fall,
  input  pwm_ctrl_t          wr_ctrl,
  input  logic               period_end,
  output pwm_ctrl_t          ctrl,
  output logic [LIN_W-1:0]   act_lin,
  output logic [SHIFT_W-1:0] act_shift,
  output logic [CNT_W-1:0]   act_top,
  output logic [CNT_W-1:0]   act_rise,
  output logic [CNT_W-1:0]   act_fall
);

  logic [LIN_W-1:0]   pend_lin;
  logic [SHIFT_W-1:0] pend_shift;
  logic [CNT_W-1:0]   pend_top;
  logic [CNT_W-1:0]   pend_rise;
  logic [CNT_W-1:0]   pend_fall;
  logic               load_act;

  // Active copy follows pending at a period end, or freely when
  // deferral is off or the counter is stopped.
  assign load_act = period_end || ctrl.sync_off || !ctrl.clk_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl       <= '0;
      pend_lin   <= '0;
      pend_shift <= '0;
      pend_top   <= '0;
      pend_rise  <= '0;
      pend_fall  <= '0;
    end else if (we) begin
      ctrl       <= wr_ctrl;
      pend_lin   <= wr_lin;
      pend_shift <= wr_shift;
      pend_top   <= wr_top;
      pend_rise  <= wr_rise;
      pend_fall  <= wr_fall;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_lin   <= '0;
      act_shift <= '0;
      act_top   <= '0;
      act_rise  <= '0;
      act_fall  <= '0;
    end else if (load_act) begin
      act_lin   <= pend_lin;
      act_shift <= pend_shift;
      act_top   <= pend_top;
      act_rise  <= pend_rise;
      act_fall  <= pend_fall;
    end
  end

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned LIN_W   = 8,
  parameter int unsigned SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [LIN_W-1:0]   lin,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);

  localparam int unsigned POW_W = (1 << SHIFT_W) - 1;

  logic [LIN_W-1:0] lin_cnt;
  logic [POW_W-1:0] pow_cnt;
  logic [POW_W:0]   pow_full;
  logic [POW_W-1:0] pow_mask;
  logic             lin_hit;
  logic             pow_hit;

  assign pow_full = ({{POW_W{1'b0}}, 1'b1} << shift) - {{POW_W{1'b0}}, 1'b1};
  assign pow_mask = pow_full[POW_W-1:0];
  assign lin_hit  = (lin_cnt >= lin);
  assign pow_hit  = (pow_cnt >= pow_mask);
  assign tick     = en && lin_hit && pow_hit;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      lin_cnt <= '0;
    end else if (lin_hit) begin
      lin_cnt <= '0;
    end else begin
      lin_cnt <= lin_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pow_cnt <= '0;
    end else if (lin_hit) begin
      if (pow_hit) begin
        pow_cnt <= '0;
      end else begin
        pow_cnt <= pow_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  assign wrap = tick && (cnt >= top);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (wrap) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_edge_out.sv
module pwm_edge_out
  import pwm_chan_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter bit          ALLOW_WRAP = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] rise,
  input  logic [CNT_W-1:0] fall,
  input  pwm_ctrl_t        ctrl,
  output logic             pwm_out
);

  logic in_win;
  logic gated;

  generate
    if (ALLOW_WRAP) begin : g_wrap
      always_comb begin
        if (rise == fall) begin
          in_win = 1'b1;
        end else if (rise < fall) begin
          in_win = (cnt >= rise) && (cnt < fall);
        end else begin
          in_win = (cnt >= rise) || (cnt < fall);
        end
      end
    end else begin : g_plain
      always_comb begin
        in_win = (rise == fall) || ((cnt >= rise) && (cnt < fall));
      end
    end
  endgenerate

  assign gated = in_win && ctrl.clk_en && ctrl.pin_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_out <= 1'b0;
    end else begin
      pwm_out <= gated ^ ctrl.invert;
    end
  end

endmodule

// File: rtl/pwm_edge_channel.sv
module pwm_edge_channel
  import pwm_chan_pkg::*;
#(
  parameter int unsigned LIN_W      = LIN_W_DEF,
  parameter int unsigned SHIFT_W    = SHIFT_W_DEF,
  parameter int unsigned CNT_W      = CNT_W_DEF,
  parameter bit          ALLOW_WRAP = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [LIN_W-1:0]   cfg_div_lin,
  input  logic [SHIFT_W-1:0] cfg_div_shift,
  input  logic [CNT_W-1:0]   cfg_top,
  input  logic [CNT_W-1:0]   cfg_rise,
  input  logic [CNT_W-1:0]   cfg_fall,
  input  logic               cfg_pin_en,
  input  logic               cfg_clk_en,
  input  logic               cfg_invert,
  input  logic               cfg_sync_off,
  output logic               pwm_out
);

  pwm_ctrl_t          wr_ctrl;
  pwm_ctrl_t          ctrl_q;
  logic [LIN_W-1:0]   act_lin;
  logic [SHIFT_W-1:0] act_shift;
  logic [CNT_W-1:0]   act_top;
  logic [CNT_W-1:0]   act_rise;
  logic [CNT_W-1:0]   act_fall;
  logic               q_tick;
  logic               p_wrap;
  logic [CNT_W-1:0]   p_cnt;

  assign wr_ctrl.pin_en   = cfg_pin_en;
  assign wr_ctrl.clk_en   = cfg_clk_en;
  assign wr_ctrl.invert   = cfg_invert;
  assign wr_ctrl.sync_off = cfg_sync_off;

  pwm_cfg_regs #(
    .LIN_W(LIN_W), .SHIFT_W(SHIFT_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we),
    .wr_lin(cfg_div_lin), .wr_shift(cfg_div_shift), .wr_top(cfg_top),
    .wr_rise(cfg_rise), .wr_fall(cfg_fall), .wr_ctrl(wr_ctrl),
    .period_end(p_wrap), .ctrl(ctrl_q),
    .act_lin(act_lin), .act_shift(act_shift), .act_top(act_top),
    .act_rise(act_rise), .act_fall(act_fall)
  );

  pwm_prescaler #(
    .LIN_W(LIN_W), .SHIFT_W(SHIFT_W)
  ) u_pre (
    .clk(clk), .rst(rst), .en(ctrl_q.clk_en),
    .lin(act_lin), .shift(act_shift), .tick(q_tick)
  );

  pwm_period_cnt #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk(clk), .rst(rst), .en(ctrl_q.clk_en), .tick(q_tick),
    .top(act_top), .cnt(p_cnt), .wrap(p_wrap)
  );

  pwm_edge_out #(
    .CNT_W(CNT_W), .ALLOW_WRAP(ALLOW_WRAP)
  ) u_out (
    .clk(clk), .rst(rst), .cnt(p_cnt), .rise(act_rise), .fall(act_fall),
    .ctrl(ctrl_q), .pwm_out(pwm_out)
  );

endmodule

// File: rtl/pwm_edge_channel_chk.sv
module pwm_edge_channel_chk
  import pwm_chan_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned ACT_W = 36
) (
  input logic             clk,
  input logic             rst,
  input logic             pwm_out,
  input pwm_ctrl_t        ctrl,
  input logic             wrap,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] rise,
  input logic [CNT_W-1:0] fall,
  input logic [ACT_W-1:0] act_bus
);

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (pwm_out == 1'b0)); // R1

  AST_PIN_GATE: assert property (@(posedge clk) disable iff (rst)
    !ctrl.pin_en |=> (pwm_out == $past(ctrl.invert))); // R6

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !ctrl.clk_en |=> (cnt == '0)); // R7

  AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ctrl.clk_en && !ctrl.sync_off && !wrap) |=> $stable(act_bus)); // R9

  AST_FULL_ON: assert property (@(posedge clk) disable iff (rst)
    (ctrl.clk_en && ctrl.pin_en && (rise == fall)) |=> (pwm_out == !$past(ctrl.invert))); // R4

endmodule

bind pwm_edge_channel pwm_edge_channel_chk #(
  .CNT_W(CNT_W), .ACT_W(LIN_W + SHIFT_W + 3 * CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .pwm_out(pwm_out), .ctrl(ctrl_q), .wrap(p_wrap),
  .cnt(p_cnt), .rise(act_rise), .fall(act_fall),
  .act_bus({act_lin, act_shift, act_top, act_rise, act_fall})
);

// File: tb/pwm_edge_channel_bench.sv
module pwm_edge_channel_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_div_lin = '0;
  logic [3:0] cfg_div_shift = '0;
  logic [7:0] cfg_top = '0;
  logic [7:0] cfg_rise = '0;
  logic [7:0] cfg_fall = '0;
  logic       cfg_pin_en = 1'b0;
  logic       cfg_clk_en = 1'b0;
  logic       cfg_invert = 1'b0;
  logic       cfg_sync_off = 1'b0;
  logic       pwm_out;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  pwm_edge_channel u_pwm_edge_channel (
    .clk(clk), .rst(rst), .cfg_we(cfg_we),
    .cfg_div_lin(cfg_div_lin), .cfg_div_shift(cfg_div_shift),
    .cfg_top(cfg_top), .cfg_rise(cfg_rise), .cfg_fall(cfg_fall),
    .cfg_pin_en(cfg_pin_en), .cfg_clk_en(cfg_clk_en),
    .cfg_invert(cfg_invert), .cfg_sync_off(cfg_sync_off),
    .pwm_out(pwm_out)
  );

  // Cycle-level reference model built from the requirements.
  int m_pl, m_ph, m_pt, m_pr, m_pf;
  int m_al, m_ah, m_at, m_ar, m_af;
  int m_s1, m_s2, m_cnt;
  bit m_pin, m_ce, m_inv, m_soff;
  bit m_out;

  function automatic bit win_of(int c, int r, int f);
    if (r == f) return 1'b1;
    if (r < f) return (c >= r) && (c < f);
    return (c >= r) || (c < f);
  endfunction

  function automatic int active_quanta(int t, int r, int f);
    if (r == f) return t + 1;
    if (r < f) return f - r;
    return (t + 1 - r) + f;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pl <= 0; m_ph <= 0; m_pt <= 0; m_pr <= 0; m_pf <= 0;
      m_al <= 0; m_ah <= 0; m_at <= 0; m_ar <= 0; m_af <= 0;
      m_s1 <= 0; m_s2 <= 0; m_cnt <= 0;
      m_pin <= 0; m_ce <= 0; m_inv <= 0; m_soff <= 0; m_out <= 0;
    end else begin
      int  mask;
      bit  s1hit, tk, endp;
      mask  = (1 << m_ah) - 1;
      s1hit = (m_s1 >= m_al);
      tk    = m_ce && s1hit && (m_s2 >= mask);
      endp  = tk && (m_cnt >= m_at);
      m_out <= ((m_ce && m_pin) ? win_of(m_cnt, m_ar, m_af) : 1'b0) ^ m_inv;
      if (!m_ce) begin
        m_s1 <= 0; m_s2 <= 0; m_cnt <= 0;
      end else begin
        m_s1 <= s1hit ? 0 : m_s1 + 1;
        if (s1hit) m_s2 <= (m_s2 >= mask) ? 0 : m_s2 + 1;
        if (endp) m_cnt <= 0;
        else if (tk) m_cnt <= m_cnt + 1;
      end
      if (endp || m_soff || !m_ce) begin
        m_al <= m_pl; m_ah <= m_ph; m_at <= m_pt; m_ar <= m_pr; m_af <= m_pf;
      end
      if (cfg_we) begin
        m_pl <= cfg_div_lin; m_ph <= cfg_div_shift; m_pt <= cfg_top;
        m_pr <= cfg_rise; m_pf <= cfg_fall;
        m_pin <= cfg_pin_en; m_ce <= cfg_clk_en;
        m_inv <= cfg_invert; m_soff <= cfg_sync_off;
      end
    end
  end

  task automatic check_bit(string req, logic got, logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: pwm_out=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_int(string req, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: active cycles=%0d expected %0d", req, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst && !done) check_bit(cur_req, pwm_out, m_out);
  end

  task automatic wr(int l, int h, int t, int r, int f,
                    bit pe, bit ce, bit inv, bit so);
    @(negedge clk);
    cfg_div_lin = 8'(l); cfg_div_shift = 4'(h); cfg_top = 8'(t);
    cfg_rise = 8'(r); cfg_fall = 8'(f);
    cfg_pin_en = pe; cfg_clk_en = ce; cfg_invert = inv; cfg_sync_off = so;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic duty_test(string req, int l, int h, int t, int r, int f);
    int per, q, hi;
    q   = (l + 1) << h;
    per = (t + 1) * q;
    cur_req = req;
    wr(l, h, t, r, f, 1'b1, 1'b0, 1'b0, 1'b0);
    wr(l, h, t, r, f, 1'b1, 1'b1, 1'b0, 1'b0);
    repeat (2 * per + 4) @(negedge clk);
    hi = 0;
    for (int i = 0; i < per; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
    check_int(req, hi, active_quanta(t, r, f) * q);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    cur_req = "R1";
    check_bit("R1", pwm_out, 1'b0);
    rst = 1'b0;
    cmp_on = 1'b1;
    repeat (3) @(negedge clk);
    check_bit("R1", pwm_out, 1'b0);

    duty_test("R3", 0, 0, 9, 0, 3);
    duty_test("R3", 1, 0, 7, 2, 6);
    duty_test("R2", 2, 1, 4, 1, 3);
    duty_test("R2", 0, 3, 3, 0, 1);
    duty_test("R4", 1, 0, 5, 2, 2);
    duty_test("R5", 0, 1, 7, 6, 2);

    // R6: pin disable forces the inactive level, also when inverted
    cur_req = "R6";
    wr(0, 1, 7, 6, 2, 1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      check_bit("R6", pwm_out, 1'b0);
      @(negedge clk);
    end
    wr(0, 1, 7, 6, 2, 1'b0, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    check_bit("R6", pwm_out, 1'b1);

    // R8: invert flips at once while fully active
    cur_req = "R8";
    wr(1, 0, 5, 2, 2, 1'b1, 1'b1, 1'b0, 1'b0);
    repeat (30) @(negedge clk);
    check_bit("R8", pwm_out, 1'b1);
    wr(1, 0, 5, 2, 2, 1'b1, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    check_bit("R8", pwm_out, 1'b0);

    // R7: stop, write new timing while stopped, resume
    cur_req = "R7";
    wr(0, 0, 9, 0, 4, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check_bit("R7", pwm_out, 1'b0);
    wr(0, 0, 5, 0, 2, 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    check_bit("R7", pwm_out, 1'b0);
    wr(0, 0, 5, 0, 2, 1'b1, 1'b1, 1'b0, 1'b0);
    repeat (40) @(negedge clk);

    // R9: deferred change mid-period
    cur_req = "R9";
    wr(1, 0, 9, 0, 5, 1'b1, 1'b1, 1'b0, 1'b0);
    repeat (37) @(negedge clk);
    wr(1, 0, 3, 0, 1, 1'b1, 1'b1, 1'b0, 1'b0);
    repeat (60) @(negedge clk);

    // R10: immediate change, including a shrinking top
    cur_req = "R10";
    wr(0, 0, 15, 0, 8, 1'b1, 1'b1, 1'b0, 1'b1);
    repeat (13) @(negedge clk);
    wr(0, 0, 4, 1, 3, 1'b1, 1'b1, 1'b0, 1'b1);
    repeat (40) @(negedge clk);

    // R11: random configurations against the model
    cur_req = "R11";
    for (int k = 0; k < 300; k++) begin
      int t;
      t = int'($urandom_range(0, 15));
      wr(int'($urandom_range(0, 3)), int'($urandom_range(0, 2)), t,
         int'($urandom_range(0, t + 1)), int'($urandom_range(0, t + 1)),
         ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) != 0),
         ($urandom_range(0, 3) == 0), ($urandom_range(0, 2) == 0));
      repeat (int'($urandom_range(5, 80))) @(negedge clk);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: cycles=150000 expected completion earlier");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule